// File: doc/BRIEF.md
# Registered Multiport Register Array

This block is a small synchronous register file of 64 words, each 72 bits wide, with two independent read ports and one write port that all share one clock. Every port presents an enable and a 6-bit address; the write port also presents a data word. All port inputs are captured in registers on the clock edge at the end of the cycle in which they are driven. The captured requests then act on the storage in the following cycle. Each read result is registered once more before it leaves the block.

Because both the request and the result are registered, the read latency is fixed at two cycles. Writes also take effect at a fixed point: a write presented in cycle n is seen by every read presented in cycle n+1 or later. A read presented in the same cycle as a write to the same word returns the word's earlier contents. The block is meant for pipelines that schedule register-file traffic statically and can rely on these exact timing rules.

Top module: `regarr_multiport`

## Requirements
- R1: The storage holds 64 words of 72 bits addressed by a 6-bit address; every word can be written and then read back unchanged through either read port.
- R2: A read with its enable high in cycle n drives the addressed word on that port's data output in cycle n+2, and not earlier.
- R3: A write with its enable high in cycle n is returned by any read to that address presented in cycle n+1 or later.
- R4: A read presented in the same cycle as a write to the same address returns the word's contents from before that write.
- R5: The two read ports act independently; in one cycle they may read the same address or different addresses, and each returns its own word.
- R6: A read port whose enable is low in cycle n keeps in cycle n+2 the data output value it had in cycle n+1.
- R7: The reset is synchronous and active low (rst_n sampled at 0 on a rising edge); it clears every captured enable and sets both read data outputs to zero, and a write presented while reset is low does not change the storage.
- R8: With the write enable low, the write address and write data have no effect on the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all ports |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write request enable |
| wr_addr_i | input | 6 | Write word address |
| wr_data_i | input | 72 | Write data word |
| rd0_en_i | input | 1 | Read port 0 request enable |
| rd0_addr_i | input | 6 | Read port 0 word address |
| rd0_data_o | output | 72 | Read port 0 registered data |
| rd1_en_i | input | 1 | Read port 1 request enable |
| rd1_addr_i | input | 6 | Read port 1 word address |
| rd1_data_o | output | 72 | Read port 1 registered data |

## Verification
A full sweep writes a distinct word into all 64 locations and reads them back with the two ports walking the address space in opposite directions, which separates address decode faults from port crosstalk. A vector table then mixes same-cycle read-and-write to one address, a read one cycle after a write, back-to-back writes to one word, idle read ports and a disabled write carrying a live address and data; each pattern tells a fault in the write visibility point, the read latency, the output hold or the write enable gating apart from correct behaviour. A reset applied mid-run while a write is presented shows whether captured enables are cleared before they can reach the storage.

// File: rtl/regarr_pkg.sv
// Package: regarr_pkg
// Shared sizing constants for the registered multiport register array.
// Assumes the word count is a power of two so the address is fully decoded.
package regarr_pkg;
    parameter int unsigned RA_WORDS    = 64;
    parameter int unsigned RA_WIDTH    = 72;
    parameter int unsigned RA_RD_PORTS = 2;
    localparam int unsigned RA_ADDR_W  = $clog2(RA_WORDS);
endpackage

// File: rtl/regarr_capture.sv
// Module: regarr_capture
// Input pipeline stage: captures every port's enable, address and write
// data on the rising clock edge. Assumes a synchronous active-low reset;
// only the enables are reset, address and data are don't-care when idle.
module regarr_capture #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 72,
    parameter int unsigned NRD    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [NRD-1:0]               rd_en,
    input  logic [NRD-1:0][ADDR_W-1:0]   rd_addr,
    output logic                         wr_en_q,
    output logic [ADDR_W-1:0]            wr_addr_q,
    output logic [DATA_W-1:0]            wr_data_q,
    output logic [NRD-1:0]               rd_en_q,
    output logic [NRD-1:0][ADDR_W-1:0]   rd_addr_q
);

    // Capture enables; reset clears them so nothing reaches the storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q <= 1'b0;
            rd_en_q <= '0;
        end else begin
            wr_en_q <= wr_en;
            rd_en_q <= rd_en;
        end
    end

    // Capture addresses and write data without reset.
    always_ff @(posedge clk) begin
        wr_addr_q <= wr_addr;
        wr_data_q <= wr_data;
        rd_addr_q <= rd_addr;
    end

    // R7
    reset_clears_en_chk: assert property (@(posedge clk)
        !rst_n |=> (wr_en_q == 1'b0 && rd_en_q == '0));

endmodule

// File: rtl/regarr_store.sv
// Module: regarr_store
// Flop-based word storage with one write port and NRD combinational read
// ports. Assumes requests arrive already registered; a read in the same
// cycle as a write to the same word sees the contents before the write.
module regarr_store #(
    parameter int unsigned WORDS  = 64,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 72,
    parameter int unsigned NRD    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
    output logic [NRD-1:0][DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    // Update the addressed word when the captured write enable is set.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One asynchronous read mux per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

    // R8
    idle_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> mem[$past(waddr)] == $past(mem[waddr]));

endmodule

// File: rtl/regarr_rdout.sv
// Module: regarr_rdout
// Output register for one read port: loads the storage word when the
// captured read enable is set, otherwise holds. Synchronous active-low
// reset clears the output to zero.
module regarr_rdout #(
    parameter int unsigned DATA_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Register read data on an enabled request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));

endmodule

// File: rtl/regarr_multiport.sv
// Module: regarr_multiport
// Registered register array with two read ports and one write port on a
// single clock. Inputs are captured, the storage is accessed in the next
// cycle and read results are registered, giving a two-cycle read latency.
// Assumes rst_n is held low for at least one rising edge before use.
module regarr_multiport
    import regarr_pkg::*;
#(
    parameter int unsigned WORDS  = RA_WORDS,
    parameter int unsigned WIDTH  = RA_WIDTH,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    input  logic              rd0_en_i,
    input  logic [ADDR_W-1:0] rd0_addr_i,
    output logic [WIDTH-1:0]  rd0_data_o,
    input  logic              rd1_en_i,
    input  logic [ADDR_W-1:0] rd1_addr_i,
    output logic [WIDTH-1:0]  rd1_data_o
);

    localparam int unsigned NRD = RA_RD_PORTS;

    logic [NRD-1:0]              rd_en;
    logic [NRD-1:0][ADDR_W-1:0]  rd_addr;
    logic                        wen_q;
    logic [ADDR_W-1:0]           waddr_q;
    logic [WIDTH-1:0]            wdata_q;
    logic [NRD-1:0]              ren_q;
    logic [NRD-1:0][ADDR_W-1:0]  raddr_q;
    logic [NRD-1:0][WIDTH-1:0]   arr_rd;
    logic [NRD-1:0][WIDTH-1:0]   rd_out;

    // Gather the named read ports into indexed vectors.
    assign rd_en   = {rd1_en_i, rd0_en_i};
    assign rd_addr = {rd1_addr_i, rd0_addr_i};

    regarr_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (WIDTH),
        .NRD    (NRD)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .wr_addr   (wr_addr_i),
        .wr_data   (wr_data_i),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .wr_en_q   (wen_q),
        .wr_addr_q (waddr_q),
        .wr_data_q (wdata_q),
        .rd_en_q   (ren_q),
        .rd_addr_q (raddr_q)
    );

    regarr_store #(
        .WORDS  (WORDS),
        .ADDR_W (ADDR_W),
        .DATA_W (WIDTH),
        .NRD    (NRD)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wen_q),
        .waddr (waddr_q),
        .wdata (wdata_q),
        .raddr (raddr_q),
        .rdata (arr_rd)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_out
        regarr_rdout #(
            .DATA_W (WIDTH)
        ) u_rdout (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ren_q[p]),
            .din   (arr_rd[p]),
            .dout  (rd_out[p])
        );
    end

    // Drive the named read data outputs.
    assign rd0_data_o = rd_out[0];
    assign rd1_data_o = rd_out[1];

endmodule

// File: tb/test_regarr_multiport.sv
module test_regarr_multiport;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en_i;
    logic [5:0]  wr_addr_i;
    logic [71:0] wr_data_i;
    logic        rd0_en_i;
    logic [5:0]  rd0_addr_i;
    logic [71:0] rd0_data_o;
    logic        rd1_en_i;
    logic [5:0]  rd1_addr_i;
    logic [71:0] rd1_data_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    regarr_multiport i_regarr_multiport (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd0_en_i   (rd0_en_i),
        .rd0_addr_i (rd0_addr_i),
        .rd0_data_o (rd0_data_o),
        .rd1_en_i   (rd1_en_i),
        .rd1_addr_i (rd1_addr_i),
        .rd1_data_o (rd1_data_o)
    );

    // Reference model and expected-output pipeline (two stages, per port).
    logic [71:0] ref_mem [64];
    logic [1:0]  p1_en, p2_en;
    logic [71:0] p1_val [2];
    logic [71:0] p2_val [2];
    string       p1_tag [2];
    string       p2_tag [2];
    logic [71:0] held [2];

    // Vector fields: [28] wen [27:22] waddr [21:14] seed [13] r0en
    // [12:7] r0addr [6] r1en [5:0] r1addr
    localparam int NVEC = 12;
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b1, 6'd3,  8'h11, 1'b1, 6'd3,  1'b0, 6'd0},
        {1'b0, 6'd0,  8'h00, 1'b1, 6'd3,  1'b1, 6'd3},
        {1'b1, 6'd10, 8'h22, 1'b0, 6'd0,  1'b1, 6'd10},
        {1'b0, 6'd0,  8'h00, 1'b0, 6'd0,  1'b0, 6'd0},
        {1'b0, 6'd0,  8'h00, 1'b1, 6'd10, 1'b1, 6'd20},
        {1'b1, 6'd20, 8'h33, 1'b1, 6'd20, 1'b1, 6'd20},
        {1'b1, 6'd20, 8'h44, 1'b1, 6'd20, 1'b0, 6'd0},
        {1'b0, 6'd20, 8'h55, 1'b1, 6'd20, 1'b1, 6'd20},
        {1'b0, 6'd0,  8'h00, 1'b0, 6'd0,  1'b1, 6'd20},
        {1'b1, 6'd63, 8'h66, 1'b1, 6'd63, 1'b1, 6'd0},
        {1'b0, 6'd0,  8'h00, 1'b1, 6'd63, 1'b1, 6'd63},
        {1'b0, 6'd0,  8'h00, 1'b0, 6'd0,  1'b0, 6'd0}
    };

    function automatic logic [71:0] seed_word(input logic [7:0] s);
        return {s, {8{~s}}};
    endfunction

    function automatic logic [71:0] init_word(input int a);
        return {8'(a), 64'h5555_5555_5555_5555};
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs against the request of two cycles ago
    // (R2 latency, R6 hold), then drive a new request and update the model.
    task automatic cycle(input logic wen, input logic [5:0] wa,
                         input logic [71:0] wd,
                         input logic r0e, input logic [5:0] r0a,
                         input logic r1e, input logic [5:0] r1a,
                         input string tag);
        logic [71:0] act [2];
        act[0] = rd0_data_o;
        act[1] = rd1_data_o;
        for (int p = 0; p < 2; p++) begin
            if (p2_en[p]) held[p] = p2_val[p];
            check(act[p] === held[p], $sformatf("%s port%0d", p2_tag[p], p),
                  act[p], held[p]);
        end
        p2_en = p1_en;
        for (int p = 0; p < 2; p++) begin
            p2_val[p] = p1_val[p];
            p2_tag[p] = p1_tag[p];
        end
        p1_en = {r1e, r0e};
        p1_val[0] = ref_mem[r0a];
        p1_val[1] = ref_mem[r1a];
        p1_tag[0] = tag;
        p1_tag[1] = tag;
        if (wen) ref_mem[wa] = wd;
        wr_en_i = wen; wr_addr_i = wa; wr_data_i = wd;
        rd0_en_i = r0e; rd0_addr_i = r0a;
        rd1_en_i = r1e; rd1_addr_i = r1a;
        @(negedge clk);
    endtask

    task automatic clear_pipe();
        p1_en = '0;
        p2_en = '0;
        for (int p = 0; p < 2; p++) begin
            held[p] = '0;
            p1_val[p] = '0;
            p2_val[p] = '0;
            p1_tag[p] = "idle";
            p2_tag[p] = "idle";
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        rd0_en_i = 1'b0; rd0_addr_i = '0;
        rd1_en_i = 1'b0; rd1_addr_i = '0;
        clear_pipe();
        @(negedge clk);
        @(negedge clk);
        // R7: outputs cleared by reset
        check(rd0_data_o === 72'd0, "R7 reset port0", rd0_data_o, 72'd0);
        check(rd1_data_o === 72'd0, "R7 reset port1", rd1_data_o, 72'd0);
        rst_n = 1'b1;

        // R1: fill every word
        for (int a = 0; a < 64; a++)
            cycle(1'b1, 6'(a), init_word(a), 1'b0, 6'd0, 1'b0, 6'd0, "R1 fill");
        // R1/R5: read all back, ports walk in opposite directions
        for (int a = 0; a < 64; a++)
            cycle(1'b0, 6'd0, 72'd0, 1'b1, 6'(a), 1'b1, 6'(63 - a), "R1 R5 readback");

        // Table: R2 R3 R4 R5 R6 R8 patterns
        for (int v = 0; v < NVEC; v++) begin
            logic [28:0] e;
            e = VEC[v];
            cycle(e[28], e[27:22], seed_word(e[21:14]), e[13], e[12:7],
                  e[6], e[5:0], $sformatf("R2 R3 R4 R6 R8 vector%0d", v));
        end
        for (int k = 0; k < 3; k++)
            cycle(1'b0, 6'd0, 72'd0, 1'b0, 6'd0, 1'b0, 6'd0, "R6 drain");

        // R2: result must not appear after only one edge
        cycle(1'b1, 6'd40, seed_word(8'h77), 1'b0, 6'd0, 1'b0, 6'd0, "R2 setup");
        cycle(1'b0, 6'd0, 72'd0, 1'b1, 6'd40, 1'b0, 6'd0, "R2 latency");
        check(rd0_data_o !== seed_word(8'h77), "R2 not at n+1", rd0_data_o,
              ~seed_word(8'h77));
        for (int k = 0; k < 3; k++)
            cycle(1'b0, 6'd0, 72'd0, 1'b0, 6'd0, 1'b0, 6'd0, "R2 drain");

        // R7: write presented during reset must be dropped
        rst_n = 1'b0;
        wr_en_i = 1'b1; wr_addr_i = 6'd5; wr_data_i = seed_word(8'h99);
        rd0_en_i = 1'b1; rd0_addr_i = 6'd5;
        @(negedge clk);
        check(rd0_data_o === 72'd0, "R7 mid-run reset port0", rd0_data_o, 72'd0);
        check(rd1_data_o === 72'd0, "R7 mid-run reset port1", rd1_data_o, 72'd0);
        rst_n = 1'b1;
        wr_en_i = 1'b0; rd0_en_i = 1'b0;
        clear_pipe();
        cycle(1'b0, 6'd0, 72'd0, 1'b1, 6'd5, 1'b1, 6'd5, "R7 write dropped");
        for (int k = 0; k < 3; k++)
            cycle(1'b0, 6'd0, 72'd0, 1'b0, 6'd0, 1'b0, 6'd0, "R7 drain");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule